// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Receiver

This block watches a received T1 bit stream, one bit per clock, and picks out the robbed-bit signaling of all 24 voice channels. Two strobes come with the stream. A frame strobe marks the framing bit of every frame, and a multiframe strobe marks the framing bit of the first frame of each multiframe. A mode input selects either the 12-frame superframe (D4) or the 24-frame extended superframe (ESF). While a multiframe is in progress, the captured bits collect in a shadow bank. At the next multiframe boundary the whole bank is copied in one step into twelve byte-wide registers. A host reads those registers through a plain address/data port.

In D4 mode only A and B bits exist. At each commit the C and D slots take the A and B values from the previous commit, so the host gets a complete picture with every poll. When the loss-of-sync input is high at a boundary, the commit is skipped and the registers keep their last good contents. A sticky multiframe flag tells the host when new signaling is ready. The serial stream is also passed straight through to an output. If a control input asks for it, the robbed-bit positions on that output are forced to one.

Top module: `t1_rbs_receiver`

## Requirements
- R1: While reset is held and directly after it, all twelve signaling registers and the flag register read 0, and `mf_irq` and `ser_out` are 0.
- R2: Address 0x60 + 3*s + g holds signal s (0=A, 1=B, 2=C, 3=D) for channel group g (0: channels 1-8, 1: 9-16, 2: 17-24). Bit i of that byte is channel 8*g + i + 1. `host_rdata` shows the addressed byte in the same cycle, and any other address except 0x6F reads 0.
- R3: A frame is 193 clocks long: the framing bit at position 0, then 24 channels of 8 bits each, MSB first. The robbed bit is the last (eighth) bit of a channel slot. It is taken in frames 6 and 12 (A, B) in D4 mode, and in frames 6, 12, 18 and 24 (A, B, C, D) in ESF mode. Frame 1 is the frame that carries the multiframe strobe.
- R4: The visible registers change only on the clock edge that ends a multiframe-strobe cycle. All of them change together, to the values captured over the multiframe just completed. The first strobe after reset only aligns the block.
- R5: In D4 mode (`esf_mode`=0) a commit loads the C registers with the A values and the D registers with the B values that were visible just before the commit.
- R6: When `sync_lost` is 1 in the multiframe-strobe cycle, no register changes and the flag is not set.
- R7: Every commit sets the flag, visible on `mf_irq` and as bit 0 at address 0x6F. The flag is cleared by a read of 0x6F or by a write to 0x6F with bit 0 set. A commit in the same cycle as a clear leaves the flag set.
- R8: With `force_ones`=0, `ser_out` equals `ser_in` delayed by exactly one clock.
- R9: With `force_ones`=1, `ser_out` is 1 one clock after every robbed-bit position of R3. All other bits pass unchanged.
- R10: Writes to the signaling register addresses have no effect on their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Received T1 serial data |
| frame_sync | input | 1 | High on the framing bit of each frame |
| mf_sync | input | 1 | High on the framing bit of frame 1 of each multiframe (together with frame_sync) |
| esf_mode | input | 1 | 1 selects the 24-frame ESF format, 0 selects the 12-frame D4 format |
| sync_lost | input | 1 | Loss-of-sync indication; blocks commits |
| force_ones | input | 1 | 1 forces the robbed-bit positions of ser_out to one |
| host_addr | input | 8 | Host register address |
| host_rd | input | 1 | Host read strobe (clears the flag when it addresses 0x6F) |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Addressed register contents |
| ser_out | output | 1 | Serial data passed through with one clock of delay |
| mf_irq | output | 1 | Multiframe flag |

## Verification
A commit can fall in the same cycle as a host clear of the flag. The bench steers its generator to the exact clock that carries the multiframe strobe and puts a read of 0x6F there. It then expects the flag to stay set, while the same read on an ordinary cycle must clear it. Loss of sync also overlaps a boundary. The bench holds `sync_lost` across a strobe and requires that neither the registers nor the flag move. The behavioural model checks every output on every clock.

// File: rtl/t1rbs_pkg.sv
`timescale 1ns/1ps
package t1rbs_pkg;

  localparam int SLOT_BITS  = 8;
  localparam int CHANNELS   = 24;
  localparam int FRAME_LEN  = 1 + CHANNELS * SLOT_BITS;
  localparam int SIG_KINDS  = 4;
  localparam int GROUPS     = CHANNELS / SLOT_BITS;
  localparam int NUM_REGS   = SIG_KINDS * GROUPS;
  localparam int ROB_STRIDE = 6;
  localparam int D4_FRAMES  = 12;
  localparam int ESF_FRAMES = 24;
  localparam int POS_W      = $clog2(FRAME_LEN + 1);
  localparam int FRM_W      = $clog2(ESF_FRAMES + 1);
  localparam int CH_W       = $clog2(CHANNELS);
  localparam int SIG_W      = $clog2(SIG_KINDS);

  typedef logic [SIG_KINDS-1:0][CHANNELS-1:0] sig_bank_t;

  // position inside the frame is the last bit of some channel slot
  function automatic logic slot_lsb(input logic [POS_W-1:0] pos);
    return (pos != '0) && (int'(pos) <= CHANNELS * SLOT_BITS) &&
           ((int'(pos) % SLOT_BITS) == 0);
  endfunction

  // frame number carries robbed bits in the selected format
  function automatic logic robbed_frame(input logic [FRM_W-1:0] frm, input logic esf);
    int lim;
    lim = esf ? ESF_FRAMES : D4_FRAMES;
    return (frm != '0) && ((int'(frm) % ROB_STRIDE) == 0) && (int'(frm) <= lim);
  endfunction

  // frame 6 -> A, 12 -> B, 18 -> C, 24 -> D
  function automatic logic [SIG_W-1:0] sig_of_frame(input logic [FRM_W-1:0] frm);
    return SIG_W'(int'(frm) / ROB_STRIDE - 1);
  endfunction

  // slot-final position -> zero-based channel
  function automatic logic [CH_W-1:0] chan_of_pos(input logic [POS_W-1:0] pos);
    return CH_W'(int'(pos) / SLOT_BITS - 1);
  endfunction

  // host byte k: signal k/GROUPS, channel group k%GROUPS, low channel in bit 0
  function automatic logic [SLOT_BITS-1:0] reg_view(input sig_bank_t bank, input int k);
    int s;
    int g;
    s = k / GROUPS;
    g = k % GROUPS;
    return bank[s][g*SLOT_BITS +: SLOT_BITS];
  endfunction

endpackage

// File: rtl/t1rbs_locator.sv
`timescale 1ns/1ps
module t1rbs_locator
  import t1rbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sync,
  input  logic             mf_sync,
  input  logic             esf_mode,
  input  logic             sync_lost,
  output logic             cap_en,
  output logic [SIG_W-1:0] cap_sig,
  output logic [CH_W-1:0]  cap_ch,
  output logic             mf_edge,
  output logic             commit
);

  logic [POS_W-1:0] pos_q, cur_pos;
  logic [FRM_W-1:0] frm_q, cur_frm;
  logic             armed_q;

  always_comb begin
    mf_edge = frame_sync & mf_sync;
    if (frame_sync)  cur_pos = '0;
    else if (&pos_q) cur_pos = pos_q;
    else             cur_pos = pos_q + POS_W'(1);
    if (mf_edge)                      cur_frm = FRM_W'(1);
    else if (frame_sync && !(&frm_q)) cur_frm = frm_q + FRM_W'(1);
    else                              cur_frm = frm_q;
    cap_en  = armed_q && slot_lsb(cur_pos) && robbed_frame(cur_frm, esf_mode);
    cap_sig = sig_of_frame(cur_frm);
    cap_ch  = chan_of_pos(cur_pos);
    commit  = mf_edge && armed_q && !sync_lost;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      frm_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      pos_q <= cur_pos;
      frm_q <= cur_frm;
      if (mf_edge) armed_q <= 1'b1;
    end
  end

  assert_no_cap_on_framing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |-> !cap_en);
  assert_frame_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mf_edge |=> (frm_q == FRM_W'(1)));
  assert_no_commit_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> !commit);

endmodule

// File: rtl/t1rbs_bank.sv
`timescale 1ns/1ps
module t1rbs_bank
  import t1rbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [SIG_W-1:0] cap_sig,
  input  logic [CH_W-1:0]  cap_ch,
  input  logic             cap_bit,
  input  logic             commit,
  input  logic             esf_mode,
  output sig_bank_t        vis
);

  sig_bank_t           shadow_q;
  sig_bank_t           vis_q;
  logic [CHANNELS-1:0] nxt [SIG_KINDS];

  always_ff @(posedge clk) begin
    if (!rst_n)      shadow_q <= '0;
    else if (cap_en) shadow_q[cap_sig][cap_ch] <= cap_bit;
  end

  // A/B slots always load from the shadow; C/D slots pick by format
  for (genvar s = 0; s < SIG_KINDS; s++) begin : g_slot
    if (s < 2) begin : g_ab
      assign nxt[s] = shadow_q[s];
    end else begin : g_cd
      assign nxt[s] = esf_mode ? shadow_q[s] : vis_q[s-2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vis_q <= '0;
    else if (commit) begin
      for (int s = 0; s < SIG_KINDS; s++) vis_q[s] <= nxt[s];
    end
  end

  assign vis = vis_q;

  assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(vis_q));
  assert_d4_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !esf_mode) |=> (vis_q[2] == $past(vis_q[0])) && (vis_q[3] == $past(vis_q[1])));
  assert_no_cap_at_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !cap_en);

endmodule

// File: rtl/t1rbs_hostport.sv
`timescale 1ns/1ps
module t1rbs_hostport
  import t1rbs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h60,
  parameter int STAT_ADDR = 'h6F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  sig_bank_t            vis,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd,
  input  logic                 wr,
  input  logic [SLOT_BITS-1:0] wdata,
  input  logic                 set_evt,
  output logic [SLOT_BITS-1:0] rdata,
  output logic                 irq
);

  logic irq_q;
  logic in_win;
  logic is_stat;
  logic clear_req;

  always_comb begin
    in_win    = (int'(addr) >= BASE_ADDR) && (int'(addr) < BASE_ADDR + NUM_REGS);
    is_stat   = (int'(addr) == STAT_ADDR);
    clear_req = is_stat && (rd || (wr && wdata[0]));
    rdata     = '0;
    if (in_win)       rdata = reg_view(vis, int'(addr) - BASE_ADDR);
    else if (is_stat) rdata = {{(SLOT_BITS-1){1'b0}}, irq_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (set_evt)   irq_q <= 1'b1;
    else if (clear_req) irq_q <= 1'b0;
  end

  assign irq = irq_q;

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> irq_q);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clear_req) |=> irq_q);
  assert_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_req && !set_evt) |=> !irq_q);
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !set_evt) |=> !irq_q);

endmodule

// File: rtl/t1_rbs_receiver.sv
`timescale 1ns/1ps
module t1_rbs_receiver
  import t1rbs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h60,
  parameter int STAT_ADDR = 'h6F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_in,
  input  logic                 frame_sync,
  input  logic                 mf_sync,
  input  logic                 esf_mode,
  input  logic                 sync_lost,
  input  logic                 force_ones,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic                 host_rd,
  input  logic                 host_wr,
  input  logic [SLOT_BITS-1:0] host_wdata,
  output logic [SLOT_BITS-1:0] host_rdata,
  output logic                 ser_out,
  output logic                 mf_irq
);

  logic             cap_en;
  logic [SIG_W-1:0] cap_sig;
  logic [CH_W-1:0]  cap_ch;
  logic             mf_edge;
  logic             commit;
  sig_bank_t        vis_w;
  logic             ser_q;

  t1rbs_locator u_loc (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .mf_sync(mf_sync),
    .esf_mode(esf_mode), .sync_lost(sync_lost), .cap_en(cap_en),
    .cap_sig(cap_sig), .cap_ch(cap_ch), .mf_edge(mf_edge), .commit(commit)
  );

  t1rbs_bank u_bank (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_sig(cap_sig),
    .cap_ch(cap_ch), .cap_bit(ser_in), .commit(commit),
    .esf_mode(esf_mode), .vis(vis_w)
  );

  t1rbs_hostport #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .STAT_ADDR(STAT_ADDR)) u_host (
    .clk(clk), .rst_n(rst_n), .vis(vis_w), .addr(host_addr), .rd(host_rd),
    .wr(host_wr), .wdata(host_wdata), .set_evt(commit),
    .rdata(host_rdata), .irq(mf_irq)
  );

  // one-clock pass-through; robbed positions optionally overwritten
  always_ff @(posedge clk) begin
    if (!rst_n) ser_q <= 1'b0;
    else        ser_q <= ser_in | (force_ones & cap_en);
  end

  assign ser_out = ser_q;

  assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !force_ones |=> (ser_out == $past(ser_in)));
  assert_forced_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ones && cap_en) |=> ser_out);
  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lost && mf_edge) |=> ($stable(vis_w) && !$rose(mf_irq)));
  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_irq) |-> $past(commit));

endmodule

// File: tb/sim_t1_rbs_receiver.sv
`timescale 1ns/1ps
module sim_t1_rbs_receiver;

  localparam int BASE = 'h60;
  localparam int STAT = 'h6F;
  localparam int FLEN = 193;
  localparam int D4MF = 12 * FLEN;
  localparam int ESFMF = 24 * FLEN;

  logic       clk = 1'b0, rst_n = 1'b0, ser_in = 1'b0;
  logic       frame_sync = 1'b0, mf_sync = 1'b0, esf_mode = 1'b0;
  logic       sync_lost = 1'b0, force_ones = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_addr = 8'h00, host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       ser_out, mf_irq;

  always #2 clk = ~clk;

  t1_rbs_receiver u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .frame_sync(frame_sync),
    .mf_sync(mf_sync), .esf_mode(esf_mode), .sync_lost(sync_lost),
    .force_ones(force_ones), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ser_out(ser_out), .mf_irq(mf_irq)
  );

  int    checks = 0, bad = 0;
  bit    done = 1'b0;
  int    g_bit = 0, g_frm = 1, auto_k = 0;
  bit    auto_addr = 1'b1;
  bit    m_armed = 1'b0, m_irq = 1'b0;
  bit    m_sh [4][24];
  bit    m_vis[4][24];
  string tag = "";

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int model_read(input int a);
    int v;
    int k;
    v = 0;
    if (a >= BASE && a < BASE + 12) begin
      k = a - BASE;
      for (int i = 0; i < 8; i++) if (m_vis[k/3][(k%3)*8 + i]) v = v | (1 << i);
    end else if (a == STAT) v = m_irq ? 1 : 0;
    return v;
  endfunction

  task automatic step();
    bit fs, mfs, rob, clr, com, exp_ser, a_old, b_old;
    int fpm, k;
    string lbl;
    @(negedge clk);
    if (auto_addr) begin
      host_addr = 8'(BASE + auto_k);
      auto_k = (auto_k + 1) % 12;
    end
    fs = (g_bit == 0);
    mfs = fs && (g_frm == 1);
    frame_sync = fs;
    mf_sync = mfs;
    ser_in = 1'($urandom % 2);
    fpm = esf_mode ? 24 : 12;
    rob = m_armed && g_bit > 0 && (g_bit % 8) == 0 && (g_frm % 6) == 0 && g_frm <= fpm;
    exp_ser = ser_in | (force_ones & rob);
    if (rob) m_sh[g_frm/6 - 1][g_bit/8 - 1] = ser_in;
    clr = (int'(host_addr) == STAT) && (host_rd || (host_wr && host_wdata[0]));
    com = mfs && m_armed && !sync_lost;
    if (com) begin
      for (int c = 0; c < 24; c++) begin
        a_old = m_vis[0][c];
        b_old = m_vis[1][c];
        m_vis[0][c] = m_sh[0][c];
        m_vis[1][c] = m_sh[1][c];
        m_vis[2][c] = esf_mode ? m_sh[2][c] : a_old;
        m_vis[3][c] = esf_mode ? m_sh[3][c] : b_old;
      end
    end
    if (com) m_irq = 1'b1;
    else if (clr) m_irq = 1'b0;
    if (mfs) m_armed = 1'b1;
    g_bit++;
    if (g_bit == FLEN) begin
      g_bit = 0;
      g_frm++;
      if (g_frm > fpm) g_frm = 1;
    end
    @(posedge clk);
    #1;
    chk((force_ones && rob) ? "R9" : "R8", 32'(ser_out), 32'(exp_ser), "ser_out");
    chk("R7", 32'(mf_irq), 32'(m_irq), "mf_irq");
    k = int'(host_addr) - BASE;
    if (tag != "") lbl = tag;
    else if (com) lbl = "R4";
    else if (k >= 6 && k < 12) lbl = esf_mode ? "R3" : "R5";
    else lbl = "R2";
    chk(lbl, 32'(host_rdata), 32'(model_read(int'(host_addr))), "host_rdata");
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic to_boundary();
    while (!(g_bit == 0 && g_frm == 1)) step();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL all watchdog expired at %0t", $time);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset contents
    for (int a = BASE; a <= STAT; a++) begin
      @(negedge clk);
      host_addr = 8'(a);
      #1;
      chk("R1", 32'(host_rdata), 32'd0, "reset read");
    end
    chk("R1", 32'(mf_irq), 32'd0, "reset mf_irq");
    chk("R1", 32'(ser_out), 32'd0, "reset ser_out");
    @(negedge clk);
    rst_n = 1'b1;

    // D4 traffic over three boundaries
    run(2 * D4MF + 60);
    // clear by read on an ordinary cycle (R7)
    auto_addr = 1'b0;
    host_addr = 8'(STAT);
    tag = "R7";
    host_rd = 1'b1;
    step();
    host_rd = 1'b0;
    to_boundary();
    // collision: commit and read-clear in the same cycle, set wins (R7)
    host_rd = 1'b1;
    step();
    host_rd = 1'b0;
    run(10);
    // clear by write of bit 0 (R7)
    host_wr = 1'b1;
    host_wdata = 8'h01;
    step();
    host_wr = 1'b0;
    step();
    // R10: writes to signaling addresses are ignored
    tag = "R10";
    host_addr = 8'(BASE);
    host_wdata = 8'hFF;
    host_wr = 1'b1;
    step();
    host_addr = 8'(BASE + 11);
    step();
    host_wr = 1'b0;
    step();
    host_addr = 8'(BASE);
    step();
    tag = "";
    auto_addr = 1'b1;

    // R6: loss of sync across a boundary
    run(500);
    sync_lost = 1'b1;
    tag = "R6";
    to_boundary();
    run(300);
    sync_lost = 1'b0;
    tag = "";

    // R9 in D4
    force_ones = 1'b1;
    run(D4MF);
    force_ones = 1'b0;

    // ESF traffic
    to_boundary();
    esf_mode = 1'b1;
    run(3 * ESFMF + 20);
    force_ones = 1'b1;
    run(ESFMF);
    force_ones = 1'b0;
    run(40);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule